// File: doc/BRIEF.md
# Machine State Image Loader

The loader takes a saved machine image as a byte stream and uses it to set up a processor before execution starts. Bytes arrive on a valid/ready handshake, and a last flag marks the end of the image. Every three bytes form one 24-bit word.

The first five words set the processor registers. The sixth word is read and dropped. Every word after that is written into memory at consecutive addresses, starting from address zero. When the stream ends, the loader writes zero to every memory address the image did not reach. It then raises `done`.

The loader also checks the framing of the stream. If it finds a fault, it stops and holds a two-bit error code until reset. It has four named states:

- `S_LOAD` accepts bytes.
- `S_FILL` writes zeros to the rest of memory.
- `S_DONE` is the terminal state after a good image.
- `S_ERR` is the terminal state after a fault.

The state transitions are:

- `S_LOAD` to `S_FILL` when the last byte arrives and memory is not yet full.
- `S_LOAD` to `S_DONE` when the last byte arrives and memory is already full.
- `S_LOAD` to `S_ERR` on a framing fault or an overflow.
- `S_FILL` to `S_DONE` after the top address is written.

Top module: `state_image_loader`

## Requirements
- R1: Bytes are packed into a 24-bit word with the first byte received as bits 23:16, the second as bits 15:8 and the third as bits 7:0.
- R2: Words 0 to 4 of the stream load these registers, in this order: instruction address, accumulator, return address, stack pointer, frame pointer. The four 20-bit registers take bits 19:0 of their word. The accumulator takes all 24 bits.
- R3: `warn` becomes 1 and stays 1 until reset if bits 23:20 are nonzero in word 0, 2, 3 or 4. Those bits have no other effect. Nonzero bits 23:20 in word 1 (the accumulator) do not set `warn`.
- R4: Word 5 is discarded. Word 6+k is written to memory address k, for k = 0, 1, 2 and so on. The write appears on `mem_we`/`mem_addr`/`mem_wdata` for one cycle.
- R5: After a well-formed stream ends, every address not yet written, up to 2^ADDR_W-1, is written with 0x000000 in increasing order. After that `done` is 1 and no further writes occur. Exactly 2^ADDR_W writes happen in total.
- R6: If `in_last` is accepted on a byte that does not complete a word, the loader enters the error state with code 1 (misaligned length). This check takes priority over code 2.
- R7: If the stream ends with a complete word but fewer than 5 words in total, the loader enters the error state with code 2 (too short).
- R8: A dump word that arrives after 2^ADDR_W memory words have already been written causes error code 3 (overflow). That word is not written.
- R9: In the error state, `in_ready` and `done` are 0, `error` is 1, and `err_code` holds its value until reset. No further memory writes occur.
- R10: During and after reset, until the first byte, `in_ready` is 1. `done`, `error`, `warn`, `mem_we`, `err_code` and all register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Loader accepts a byte |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks final byte of the image |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 24 | Memory write data |
| iar_o | output | 20 | Instruction address register value |
| acc_o | output | 24 | Accumulator value |
| ra_o | output | 20 | Return address value |
| sp_o | output | 20 | Stack pointer value |
| fp_o | output | 20 | Frame pointer value |
| warn | output | 1 | Sticky padding-bit warning |
| done | output | 1 | Image loaded and memory filled |
| error | output | 1 | Loader stopped on a fault |
| err_code | output | 2 | 0 none, 1 misaligned, 2 short, 3 overflow |

## Verification
Assertions check the following on every cycle:

- `done` and `error` are never 1 at the same time.
- Back-to-back memory writes use addresses that increase by one.
- The first write after reset goes to address zero.
- Every cycle of the fill phase writes zero.
- An error holds its code and blocks further writes.
- Nothing is written once `done` has settled.

Only the bench's scenarios can show the rest:

- That each word reaches the right register, with the correct byte order.
- That word 5 is dropped.
- Which error code each stream length produces. The bench sweeps every length below the minimum, every dump length up to full memory, and one word past it.
- That the warning flag tracks the padding bits slot by slot.

// File: rtl/sil_pkg.sv
package sil_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 24;
    localparam int PTR_W     = 20;
    localparam int REG_SLOTS = 5;
    localparam int ACC_SLOT  = 1;
    localparam int DUMP_SLOT = 6;
    localparam int IDX_W     = 3;

    typedef enum logic [1:0] {
        S_LOAD = 2'd0,
        S_FILL = 2'd1,
        S_DONE = 2'd2,
        S_ERR  = 2'd3
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ALIGN = 2'd1,
        ERR_SHORT = 2'd2,
        ERR_OVFL  = 2'd3
    } ld_err_e;
endpackage

// File: rtl/sil_byte_packer.sv
module sil_byte_packer
    import sil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BYTE_W-1:0] data,
    output logic              word_end,
    output logic              word_fire,
    output logic [WORD_W-1:0] word
);
    localparam int BPW    = WORD_W / BYTE_W;
    localparam int PH_W   = $clog2(BPW);
    localparam int HOLD_W = WORD_W - BYTE_W;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BPW - 1);

    logic [PH_W-1:0]   phase_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            hold_q  <= '0;
        end else if (accept) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            hold_q  <= {hold_q[HOLD_W-BYTE_W-1:0], data};
        end
    end

    assign word_end  = (phase_q == PH_LAST);
    assign word_fire = accept && word_end;
    assign word      = {hold_q, data};

    // R1: byte phase never leaves its range
    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PH_LAST);
    // R1: after a completed word the phase restarts at the first byte
    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_fire |=> phase_q == '0);
endmodule

// File: rtl/sil_reg_bank.sv
module sil_reg_bank
    import sil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  slot,
    input  logic [WORD_W-1:0] word,
    output logic [PTR_W-1:0]  iar_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [PTR_W-1:0]  ra_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic [PTR_W-1:0]  fp_o,
    output logic              warn
);
    localparam int NPTR = REG_SLOTS - 1;
    localparam int PAD_W = WORD_W - PTR_W;

    logic [PTR_W-1:0]  ptr_q [NPTR];
    logic [WORD_W-1:0] acc_q;
    logic              warn_q;

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        localparam int SLOT = (p < ACC_SLOT) ? p : p + 1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[p] <= '0;
            else if (load && slot == IDX_W'(SLOT))
                ptr_q[p] <= word[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            warn_q <= 1'b0;
        end else if (load) begin
            if (slot == IDX_W'(ACC_SLOT))
                acc_q <= word;
            else if (|word[WORD_W-1:WORD_W-PAD_W])
                warn_q <= 1'b1;
        end
    end

    assign iar_o = ptr_q[0];
    assign ra_o  = ptr_q[1];
    assign sp_o  = ptr_q[2];
    assign fp_o  = ptr_q[3];
    assign acc_o = acc_q;
    assign warn  = warn_q;

    // R3: the warning flag never clears once set
    p_warn_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warn_q |=> warn_q);
endmodule

// File: rtl/state_image_loader.sv
module state_image_loader
    import sil_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [23:0]       mem_wdata,
    output logic [19:0]       iar_o,
    output logic [23:0]       acc_o,
    output logic [19:0]       ra_o,
    output logic [19:0]       sp_o,
    output logic [19:0]       fp_o,
    output logic              warn,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);
    localparam logic [ADDR_W:0]  CNT_LAST = (ADDR_W+1)'((1 << ADDR_W) - 1);
    localparam logic [IDX_W-1:0] IDX_DUMP = IDX_W'(DUMP_SLOT);
    localparam logic [IDX_W-1:0] IDX_REGS = IDX_W'(REG_SLOTS);
    localparam logic [IDX_W-1:0] IDX_MINL = IDX_W'(REG_SLOTS - 1);

    ld_state_e         state_q, state_d;
    ld_err_e           err_q, err_d;
    logic [IDX_W-1:0]  widx_q;
    logic [ADDR_W:0]   cnt_q;
    logic              accept, word_end, word_fire, reg_load, do_write;
    logic              cnt_full, cnt_last;
    logic [WORD_W-1:0] word, wdata_d;
    logic              mem_we_q, wrote_q;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [WORD_W-1:0] mem_wdata_q;

    assign in_ready = (state_q == S_LOAD);
    assign accept   = in_valid && in_ready;
    assign cnt_full = cnt_q[ADDR_W];
    assign cnt_last = (cnt_q == CNT_LAST);

    sil_byte_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .data      (in_data),
        .word_end  (word_end),
        .word_fire (word_fire),
        .word      (word)
    );

    sil_reg_bank u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reg_load),
        .slot  (widx_q),
        .word  (word),
        .iar_o (iar_o),
        .acc_o (acc_o),
        .ra_o  (ra_o),
        .sp_o  (sp_o),
        .fp_o  (fp_o),
        .warn  (warn)
    );

    always_comb begin
        state_d  = state_q;
        err_d    = err_q;
        do_write = 1'b0;
        reg_load = 1'b0;
        wdata_d  = word;
        unique case (state_q)
            S_LOAD: begin
                if (accept && in_last && !word_end) begin
                    state_d = S_ERR;
                    err_d   = ERR_ALIGN;
                end else if (word_fire) begin
                    reg_load = (widx_q < IDX_REGS);
                    if (widx_q == IDX_DUMP) begin
                        if (cnt_full) begin
                            state_d = S_ERR;
                            err_d   = ERR_OVFL;
                        end else begin
                            do_write = 1'b1;
                        end
                    end
                    if (in_last && state_d != S_ERR) begin
                        if (widx_q < IDX_MINL) begin
                            state_d = S_ERR;
                            err_d   = ERR_SHORT;
                        end else if (cnt_full || (do_write && cnt_last)) begin
                            state_d = S_DONE;
                        end else begin
                            state_d = S_FILL;
                        end
                    end
                end
            end
            S_FILL: begin
                do_write = 1'b1;
                wdata_d  = '0;
                if (cnt_last) state_d = S_DONE;
            end
            S_DONE: ;
            S_ERR:  ;
            default: ;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOAD;
            err_q   <= ERR_NONE;
            widx_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (word_fire && widx_q != IDX_DUMP) widx_q <= widx_q + 1'b1;
            if (do_write) cnt_q <= cnt_q + 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
            wrote_q     <= 1'b0;
        end else begin
            mem_we_q <= do_write;
            if (mem_we_q) wrote_q <= 1'b1;
            if (do_write) begin
                mem_addr_q  <= cnt_q[ADDR_W-1:0];
                mem_wdata_q <= wdata_d;
            end
        end
    end

    assign mem_we    = mem_we_q;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;
    assign done      = (state_q == S_DONE);
    assign error     = (state_q == S_ERR);
    assign err_code  = err_q;

    // R5/R9: terminal outcomes are exclusive
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    // R9: an error is held with its code and no write follows
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error && $stable(err_code) && !mem_we);
    // R4: back-to-back writes walk upward by one address
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
    // R4: the first write after reset targets address zero
    p_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wrote_q) |-> mem_addr == '0);
    // R5: every fill cycle emits a zero write
    p_fill_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL) |=> mem_we && mem_wdata == '0);
    // R5: once done has settled, no write occurs
    p_quiet_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> !mem_we);
endmodule

// File: tb/state_image_loader_tb.sv
module state_image_loader_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [23:0]   mem_wdata;
    logic [19:0]   iar_o, ra_o, sp_o, fp_o;
    logic [23:0]   acc_o;
    logic          warn, done, error;
    logic [1:0]    err_code;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    logic clr_model = 1'b0;
    logic [23:0] model [DEPTH];
    logic [23:0] wbuf [32];

    always #2.5 clk = ~clk;

    state_image_loader #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .iar_o(iar_o),
        .acc_o(acc_o), .ra_o(ra_o), .sp_o(sp_o), .fp_o(fp_o), .warn(warn),
        .done(done), .error(error), .err_code(err_code)
    );

    always @(posedge clk) begin
        if (clr_model) begin
            for (int i = 0; i < DEPTH; i++) model[i] <= 24'hAAAAAA;
            wcount <= 0;
        end else if (mem_we) begin
            model[mem_addr] <= mem_wdata;
            wcount <= wcount + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clr_model = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; clr_model = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_stream(int nbytes);
        for (int k = 0; k < nbytes; k++) begin
            logic [23:0] w;
            w = wbuf[k / 3];
            in_valid = 1'b1;
            in_data  = w[8*(2 - k % 3) +: 8];
            in_last  = (k == nbytes - 1);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (k % 5 == 4) @(negedge clk);
        end
    endtask

    task automatic wait_end();
        for (int c = 0; c < 100 && !done && !error; c++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [23:0] dump_word(int n, int i);
        return 24'hC00000 | 24'(n << 8) | 24'(i + 1);
    endfunction

    task automatic fill_regs(int n);
        wbuf[0] = 24'h0ABCD0 + 24'(n);
        wbuf[1] = 24'hF12340 + 24'(n);
        wbuf[2] = 24'h012345 + 24'(n);
        wbuf[3] = 24'h0FEDC0 + 24'(n);
        wbuf[4] = 24'h055550 + 24'(n);
        wbuf[5] = 24'h5A5A5A;
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 ready", in_ready, 1);
        check("R10 done/error/warn/we", {done, error, warn, mem_we}, 0);
        check("R10 code", err_code, 0);
        check("R10 regs", iar_o | ra_o | sp_o | fp_o | 20'(acc_o), 0);

        // R1 R2 R4 R5: dump lengths 0..DEPTH; n=-1 means only five words
        for (int n = -1; n <= DEPTH; n++) begin
            int nw;
            int nd;
            nd = (n < 0) ? 0 : n;
            nw = (n < 0) ? 5 : 6 + n;
            do_reset();
            fill_regs(nd);
            for (int i = 0; i < nd; i++) wbuf[6 + i] = dump_word(nd, i);
            send_stream(3 * nw);
            wait_end();
            check("R5 done", {done, error}, 2'b10);
            check("R2 iar", iar_o, 20'h0ABCD0 + 20'(nd));
            check("R2 acc", acc_o, 24'hF12340 + 24'(nd));
            check("R2 ra", ra_o, 20'h012345 + 20'(nd));
            check("R2 sp", sp_o, 20'h0FEDC0 + 20'(nd));
            check("R2 fp", fp_o, 20'h055550 + 20'(nd));
            check("R3 no warn for acc padding", warn, 0);
            check("R5 write count", wcount, DEPTH);
            for (int a = 0; a < DEPTH; a++) begin
                if (a < nd) check("R4 R1 dump word", model[a], dump_word(nd, a));
                else        check("R5 zero fill", model[a], 0);
            end
            check("R5 ready low", in_ready, 0);
        end

        // R8: one dump word too many
        do_reset();
        fill_regs(9);
        for (int i = 0; i <= DEPTH; i++) wbuf[6 + i] = dump_word(9, i);
        send_stream(3 * (7 + DEPTH));
        wait_end();
        check("R8 error", {done, error}, 2'b01);
        check("R8 code", err_code, 3);
        check("R8 writes", wcount, DEPTH);
        for (int a = 0; a < DEPTH; a++) check("R8 kept", model[a], dump_word(9, a));

        // R6 R7: every length below the minimum, and some long odd ones
        for (int len = 1; len <= 23; len++) begin
            if (len <= 14 || len == 20 || len == 22) begin
                do_reset();
                fill_regs(0);
                for (int i = 6; i < 8; i++) wbuf[i] = 24'h123456;
                send_stream(len);
                wait_end();
                check(len % 3 != 0 ? "R6 code" : "R7 code", err_code,
                      (len % 3 != 0) ? 1 : 2);
                check("R9 error state", {done, error, in_ready}, 3'b010);
            end
        end

        // R3: padding bits in each register slot
        for (int s = 0; s < 5; s++) begin
            do_reset();
            for (int i = 0; i < 6; i++) wbuf[i] = 24'h000111 * 24'(i + 1);
            wbuf[s] = wbuf[s] | 24'h900000;
            send_stream(18);
            wait_end();
            check("R3 warn", warn, (s != 1) ? 1 : 0);
            if (s == 0) check("R3 iar low bits", iar_o, 20'h00111);
            if (s == 1) check("R3 acc full", acc_o, 24'h900222);
        end

        // R9: error hold while further bytes are offered
        do_reset();
        fill_regs(0);
        send_stream(9);
        wait_end();
        in_valid = 1'b1; in_data = 8'hFF; in_last = 1'b1;
        repeat (20) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R9 held code", err_code, 2);
        check("R9 held state", {done, error, in_ready, mem_we}, 4'b0100);
        check("R9 no writes", wcount, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule